// File: doc/BRIEF.md
# Boot-Remappable Chip Select Decoder

This block turns a 32-bit bus address into one region select. The top four address bits pick one of eight 256 MB segments. Six of the segments drive active-low select lines for external devices. The other two select the on-chip SRAM and the on-chip boot ROM. Addresses above the eighth segment select nothing and raise an unmapped flag.

A boot-mode input is sampled while power-on reset is held and is frozen when reset is released. When that input is low, the block boots from internal ROM. In that mode the ROM sits at the bottom of the map and the SRAM just above it, and the external selects run in reverse order. Otherwise the external selects come first in natural order, followed by the SRAM and the ROM. The block also produces an SRAM byte offset folded into a power-of-two frame-buffer window, so accesses beyond that window wrap back into it.

The decode is purely combinational from the address. The only state is the one-bit boot latch.

Top module: `boot_cs_decoder`

## Requirements
- R1: At most one of the eight selects (`cs_n` low bits, `sram_sel`, `rom_sel`) is asserted for any address, and it is chosen by `addr[31:28]` in the same cycle, with no clock edge in between.
- R2: In normal mode, segment values 0 through 5 drive `cs_n[seg]` low.
- R3: In normal mode, segment 6 asserts `sram_sel` and segment 7 asserts `rom_sel`.
- R4: In boot-from-ROM mode, segment 0 asserts `rom_sel` and segment 1 asserts `sram_sel`.
- R5: In boot-from-ROM mode, segment k (2 to 7) drives `cs_n[7-k]` low, so segment 2 selects line 5 and segment 7 selects line 0.
- R6: A segment value of 8 or above asserts no select and drives `unmapped` high. Any value of 7 or below drives `unmapped` low.
- R7: While `por_n` is low, the boot mode is taken from `media_n` at every rising clock edge (low means boot-from-ROM). While `por_n` is high, the mode holds and changes on `media_n` have no effect.
- R8: `sram_addr` equals `addr[16:0]` with every bit at position `fb_log2` and above cleared. A `fb_log2` value above 17 acts as 17, which gives the full 128 KB window.
- R9: The ROM segment is fully decoded: `rom_sel` is asserted for every offset within its segment, from the lowest to the highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the boot latch |
| por_n | input | 1 | Active-low power-on reset; the boot mode is sampled while it is low |
| media_n | input | 1 | Boot strap; a low value at reset release selects boot-from-ROM |
| addr | input | 32 | Bus address |
| fb_log2 | input | 5 | Base-2 logarithm of the SRAM window size in bytes |
| cs_n | output | 6 | Active-low external segment selects |
| sram_sel | output | 1 | On-chip SRAM select |
| rom_sel | output | 1 | On-chip ROM select |
| unmapped | output | 1 | Address lies above all eight segments |
| sram_addr | output | 17 | SRAM byte offset folded into the window |

## Verification
A wrong boot latch shows up at once as a different mapping at every address. The ROM and SRAM swap places with external lines, and the external order flips. A single probe of segment 0 after reset release exposes it, and a second probe after `media_n` toggles shows whether the latch leaks. A wrong window mask shows only on SRAM accesses whose offset bits lie at or above `fb_log2`. For that reason the vectors cover window sizes of 0, a mid value, 17 and a value above 17.

// File: rtl/boot_cs_decoder.sv
module boot_cs_decoder #(
  parameter int AW      = 32,
  parameter int SEG_W   = 4,
  parameter int NUM_EXT = 6,
  parameter int SRAM_AW = 17,
  parameter int FBW     = $clog2(SRAM_AW + 1)
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               media_n,
  input  logic [AW-1:0]      addr,
  input  logic [FBW-1:0]     fb_log2,
  output logic [NUM_EXT-1:0] cs_n,
  output logic               sram_sel,
  output logic               rom_sel,
  output logic               unmapped,
  output logic [SRAM_AW-1:0] sram_addr
);
  localparam int NUM_SEG = NUM_EXT + 2;
  localparam logic [SEG_W-1:0] SEG_LIMIT  = SEG_W'(NUM_SEG);
  localparam logic [SEG_W-1:0] NRM_SRAM   = SEG_W'(NUM_EXT);
  localparam logic [SEG_W-1:0] NRM_ROM    = SEG_W'(NUM_EXT + 1);
  localparam logic [SEG_W-1:0] BOOT_ROM   = SEG_W'(0);
  localparam logic [SEG_W-1:0] BOOT_SRAM  = SEG_W'(1);
  localparam logic [FBW-1:0]   FB_MAX     = FBW'(SRAM_AW);

  logic             boot_q;
  logic [SEG_W-1:0] seg;
  logic             in_map;
  logic [FBW-1:0]   fb_eff;

  always_ff @(posedge clk)
    if (!por_n) boot_q <= ~media_n;

  assign seg    = addr[AW-1 -: SEG_W];
  assign in_map = seg < SEG_LIMIT;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    localparam logic [SEG_W-1:0] NAT = SEG_W'(i);
    localparam logic [SEG_W-1:0] REV = SEG_W'(NUM_SEG - 1 - i);
    assign cs_n[i] = !(in_map && (seg == (boot_q ? REV : NAT)));
  end

  assign sram_sel = in_map && (seg == (boot_q ? BOOT_SRAM : NRM_SRAM));
  assign rom_sel  = in_map && (seg == (boot_q ? BOOT_ROM  : NRM_ROM));
  assign unmapped = !in_map;

  assign fb_eff    = (fb_log2 > FB_MAX) ? FB_MAX : fb_log2;
  assign sram_addr = addr[SRAM_AW-1:0] & ~({SRAM_AW{1'b1}} << fb_eff);

  p_single_sel_r1: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({~cs_n, sram_sel, rom_sel}));

  p_unmapped_quiet_r6: assert property (@(posedge clk) disable iff (!por_n)
    unmapped |-> (&cs_n && !sram_sel && !rom_sel));

  p_mapped_one_r6: assert property (@(posedge clk) disable iff (!por_n)
    !unmapped |-> ($countones({~cs_n, sram_sel, rom_sel}) == 1));

  p_boot_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> $stable(boot_q));

  p_boot_rom_low_r4: assert property (@(posedge clk) disable iff (!por_n)
    (boot_q && rom_sel) |-> (seg == BOOT_ROM));

  p_sram_subset_r8: assert property (@(posedge clk) disable iff (!por_n)
    (sram_addr & ~addr[SRAM_AW-1:0]) == '0);
endmodule

// File: tb/boot_cs_decoder_bench.sv
module boot_cs_decoder_bench;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        media_n = 1'b1;
  logic [31:0] addr = '0;
  logic [4:0]  fb_log2 = 5'd17;
  logic [5:0]  cs_n;
  logic        sram_sel, rom_sel, unmapped;
  logic [16:0] sram_addr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  boot_cs_decoder u_boot_cs_decoder (
    .clk(clk), .por_n(por_n), .media_n(media_n), .addr(addr), .fb_log2(fb_log2),
    .cs_n(cs_n), .sram_sel(sram_sel), .rom_sel(rom_sel), .unmapped(unmapped),
    .sram_addr(sram_addr)
  );

  // {boot, addr, fb_log2, exp_cs_n, exp_sram, exp_rom, exp_unmapped, exp_sram_addr}
  localparam int NV = 21;
  localparam logic [63:0] VEC [NV] = '{
    {1'b0, 32'h0000_1234, 5'd17, 6'b111110, 1'b0, 1'b0, 1'b0, 17'h0},
    {1'b0, 32'h1ABC_0000, 5'd17, 6'b111101, 1'b0, 1'b0, 1'b0, 17'h0},
    {1'b0, 32'h5FFF_FFFF, 5'd17, 6'b011111, 1'b0, 1'b0, 1'b0, 17'h0},
    {1'b0, 32'h6001_2345, 5'd17, 6'b111111, 1'b1, 1'b0, 1'b0, 17'h12345},
    {1'b0, 32'h6003_2345, 5'd17, 6'b111111, 1'b1, 1'b0, 1'b0, 17'h12345},
    {1'b0, 32'h6000_FFFF, 5'd10, 6'b111111, 1'b1, 1'b0, 1'b0, 17'h003FF},
    {1'b0, 32'h6000_FFFF, 5'd20, 6'b111111, 1'b1, 1'b0, 1'b0, 17'h0FFFF},
    {1'b0, 32'h6000_FFFF, 5'd0,  6'b111111, 1'b1, 1'b0, 1'b0, 17'h0},
    {1'b0, 32'h7FFF_FFFF, 5'd17, 6'b111111, 1'b0, 1'b1, 1'b0, 17'h0},
    {1'b0, 32'h8000_0000, 5'd17, 6'b111111, 1'b0, 1'b0, 1'b1, 17'h0},
    {1'b0, 32'hF123_4567, 5'd17, 6'b111111, 1'b0, 1'b0, 1'b1, 17'h0},
    {1'b1, 32'h0000_0010, 5'd17, 6'b111111, 1'b0, 1'b1, 1'b0, 17'h0},
    {1'b1, 32'h1002_0004, 5'd16, 6'b111111, 1'b1, 1'b0, 1'b0, 17'h00004},
    {1'b1, 32'h1001_8004, 5'd15, 6'b111111, 1'b1, 1'b0, 1'b0, 17'h00004},
    {1'b1, 32'h2000_0000, 5'd17, 6'b011111, 1'b0, 1'b0, 1'b0, 17'h0},
    {1'b1, 32'h3000_0000, 5'd17, 6'b101111, 1'b0, 1'b0, 1'b0, 17'h0},
    {1'b1, 32'h4000_0000, 5'd17, 6'b110111, 1'b0, 1'b0, 1'b0, 17'h0},
    {1'b1, 32'h5000_0000, 5'd17, 6'b111011, 1'b0, 1'b0, 1'b0, 17'h0},
    {1'b1, 32'h6000_0000, 5'd17, 6'b111101, 1'b0, 1'b0, 1'b0, 17'h0},
    {1'b1, 32'h7FFF_0000, 5'd17, 6'b111110, 1'b0, 1'b0, 1'b0, 17'h0},
    {1'b1, 32'h9000_0000, 5'd17, 6'b111111, 1'b0, 1'b0, 1'b1, 17'h0}
  };

  task automatic do_reset(input logic strap);
    @(negedge clk);
    por_n = 1'b0;
    media_n = strap;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
  endtask

  task automatic check(input string req, input logic [5:0] e_cs, input logic e_sr,
                       input logic e_rom, input logic e_un, input logic chk_sa,
                       input logic [16:0] e_sa);
    checks++;
    if (cs_n !== e_cs || sram_sel !== e_sr || rom_sel !== e_rom || unmapped !== e_un ||
        (chk_sa && sram_addr !== e_sa)) begin
      errors++;
      $display("FAIL %s addr=%h: got cs_n=%b sram=%b rom=%b unm=%b sa=%h, exp cs_n=%b sram=%b rom=%b unm=%b sa=%h",
               req, addr, cs_n, sram_sel, rom_sel, unmapped, sram_addr,
               e_cs, e_sr, e_rom, e_un, e_sa);
    end
  endtask

  function automatic string tag_of(input logic [63:0] v);
    if (v[17]) return "R6";
    if (v[19] && !v[63]) return "R3/R8";
    if (v[19] || v[18]) return v[63] ? "R4/R8" : "R3/R9";
    return v[63] ? "R5" : "R2";
  endfunction

  initial begin
    logic mode;
    mode = 1'b0;
    // reset state: normal strap, addr in segment 7 while por_n low
    addr = 32'h7000_0000;
    repeat (2) @(negedge clk);
    #1 check("R7 reset", 6'b111111, 1'b0, 1'b1, 1'b0, 1'b0, 17'h0);
    por_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][63] != mode) begin
        mode = VEC[i][63];
        do_reset(~mode);
      end
      @(negedge clk);
      addr = VEC[i][62:31];
      fb_log2 = VEC[i][30:26];
      #1 check(tag_of(VEC[i]), VEC[i][25:20], VEC[i][19], VEC[i][18], VEC[i][17],
               VEC[i][19], VEC[i][16:0]);
    end
    // R7: strap change after release has no effect (boot mode held)
    @(negedge clk);
    media_n = 1'b1;
    repeat (3) @(negedge clk);
    addr = 32'h0000_0000;
    #1 check("R7 hold boot", 6'b111111, 1'b0, 1'b1, 1'b0, 1'b0, 17'h0);
    // R7: last sample before release wins
    @(negedge clk);
    por_n = 1'b0;
    media_n = 1'b0;
    repeat (3) @(negedge clk);
    media_n = 1'b1;
    @(negedge clk);
    por_n = 1'b1;
    media_n = 1'b0;
    repeat (2) @(negedge clk);
    addr = 32'h0000_0000;
    #1 check("R7 last sample", 6'b111110, 1'b0, 1'b0, 1'b0, 1'b0, 17'h0);
    // R9: lowest ROM offset in normal mode
    addr = 32'h7000_0000;
    #1 check("R9 rom low", 6'b111111, 1'b0, 1'b1, 1'b0, 1'b0, 17'h0);
    // R1: change between edges, decode follows with no clock
    @(posedge clk);
    #2 addr = 32'h3000_0000;
    #1 check("R1 comb", 6'b110111, 1'b0, 1'b0, 1'b0, 1'b0, 17'h0);
    addr = 32'h6001_FFFF; fb_log2 = 5'd17;
    #1 check("R1/R8 comb", 6'b111111, 1'b1, 1'b0, 1'b0, 1'b1, 17'h1FFFF);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule